// File: doc/BRIEF.md
# Three-Channel LED Program Sequencer

This block holds a small instruction store for each of the red, green and blue LED channels. It walks each store with its own program counter, one slot at a time. A host picks each channel's operating mode. It fills a channel's store while that channel is in the loading mode, and it can place a channel's counter at any slot to choose where its program starts. An external executor interprets the fetched instruction and pulses a per-channel done line when that instruction is finished. On that pulse the sequencer steps to the next slot. After the last slot the counter returns to slot zero.

Mode changes and counter writes do not take effect when the host issues them. They are held until the next pulse of a slow timebase, which stands for a 32 kHz clock divided down from the fast system clock. While any channel is loading, every other channel stops stepping and asserts a hold flag, so its PWM value stays where it was. A zero-current flag marks channels that are switched off.

Top module: `led_seq_top`

## Requirements
- R1: After reset every channel is off, every program counter reads 0, every zero-current flag is high, and every instruction-valid and PWM-hold output is low.
- R2: The mode code for channel c sits at bits [2c+1:2c] of `mode_val`. The codes are 00 off, 01 load, 10 run and 11 hold. A mode write takes effect only on a slow tick. Hold (11) keeps zero-current low and instruction-valid low.
- R3: In off mode the zero-current flag is high and the program counter is forced to 0. A counter write to an off channel leaves it at 0.
- R4: A channel that enters load mode has its program counter reset to 0.
- R5: Store writes and reads reach only a channel that is currently in load mode. A write to any other channel is dropped. A read of any other channel returns 0.
- R6: In run mode with no freeze, `instr` shows the slot addressed by the counter and instruction-valid is high. Each done pulse advances the counter by exactly one, at a slow tick.
- R7: The counter steps from slot SLOTS-1 to slot 0.
- R8: A program-counter write moves the channel's counter to the written slot at the next slow tick.
- R9: While one or more channels are in load mode, every channel not in load mode raises PWM-hold, drops instruction-valid and ignores done pulses. Execution resumes from the same slot once no channel is loading.
- R10: In hold mode the counter stays put and done pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Strobe that requests the modes on `mode_val` for all channels |
| mode_val | input | 2*NUM_CH | Requested mode codes, 2 bits per channel |
| pc_wr | input | 1 | Strobe that requests a counter write |
| pc_ch | input | CH_W | Channel targeted by the counter write |
| pc_val | input | PC_W | Slot to start from |
| mem_wr | input | 1 | Store write strobe |
| mem_ch | input | CH_W | Channel addressed for store access |
| mem_addr | input | PC_W | Slot addressed for store access |
| mem_wdata | input | IW | Instruction word to write |
| mem_rdata | output | IW | Store read data, 0 unless the addressed channel is loading |
| exec_done | input | NUM_CH | Per-channel completion pulse from the executor |
| instr | output | NUM_CH*IW | Fetched instruction for each channel |
| instr_valid | output | NUM_CH | Channel is running and not frozen |
| pc_out | output | NUM_CH*PC_W | Program counter of each channel |
| pwm_hold | output | NUM_CH | Channel frozen by another channel's load |
| zero_cur | output | NUM_CH | Channel is off and its current is forced to 0 |

## Verification
The bench builds the block with three channels, sixteen slots of 16 bits and a slow tick every 4 system clocks instead of several thousand. With that divider a mode change, a counter write or a single step settles within a dozen cycles. So the bench can walk a counter across the 15-to-0 wrap and take channels in and out of load mode many times. Waits that span several ticks remove any dependence on the tick phase. Each single done pulse can then be counted as exactly one step, or as none when the channel is frozen or held.

// File: rtl/led_seq_pkg.sv
package led_seq_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_LOAD = 2'b01,
        MODE_RUN  = 2'b10,
        MODE_HOLD = 2'b11
    } seq_mode_e;

    typedef struct packed {
        logic valid;
        logic hold;
        logic zero;
    } chan_flags_t;

    function automatic seq_mode_e decode_mode(input logic [1:0] code);
        return seq_mode_e'(code);
    endfunction

    function automatic logic resets_pc(input seq_mode_e cur, input seq_mode_e nxt);
        return (nxt == MODE_OFF) || (nxt == MODE_LOAD && cur != MODE_LOAD);
    endfunction

endpackage

// File: rtl/led_seq_tick.sv
module led_seq_tick #(
    parameter int TICK_DIV = 7813
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [CW-1:0] cnt_q;

    generate
        if (TICK_DIV > 1) begin : g_div
            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt_q <= '0;
                    tick  <= 1'b0;
                end else if (cnt_q == CW'(TICK_DIV - 1)) begin
                    cnt_q <= '0;
                    tick  <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                    tick  <= 1'b0;
                end
            end

            // R2: the slow timebase never pulses on two edges in a row
            a_r2_tick_gap: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end else begin : g_pass
            always_ff @(posedge clk) begin
                cnt_q <= '0;
                tick  <= !rst;
            end
        end
    endgenerate

endmodule

// File: rtl/led_seq_chan.sv
module led_seq_chan
    import led_seq_pkg::*;
#(
    parameter int SLOTS = 16,
    parameter int IW    = 16,
    parameter int PC_W  = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            mode_wr,
    input  seq_mode_e       mode_new,
    input  logic            pc_wr,
    input  logic [PC_W-1:0] pc_new,
    input  logic            mem_we,
    input  logic [PC_W-1:0] mem_addr,
    input  logic [IW-1:0]   mem_wdata,
    output logic [IW-1:0]   mem_rdata,
    input  logic            done,
    input  logic            frozen,
    output logic            is_load,
    output logic [PC_W-1:0] pc,
    output logic [IW-1:0]   instr,
    output chan_flags_t     flags
);
    seq_mode_e       mode_q, mode_req_q;
    logic            pcv_q;
    logic [PC_W-1:0] pcreq_q, pc_q;
    logic            done_q;
    logic [IW-1:0]   mem_q [SLOTS];
    logic            active, step;

    assign active = (mode_q == MODE_RUN) && !frozen;
    assign step   = tick && active && (done_q || done);

    always_ff @(posedge clk) begin
        if (rst)          mode_req_q <= MODE_OFF;
        else if (mode_wr) mode_req_q <= mode_new;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pcv_q   <= 1'b0;
            pcreq_q <= '0;
        end else if (pc_wr) begin
            pcv_q   <= 1'b1;
            pcreq_q <= pc_new;
        end else if (tick) begin
            pcv_q   <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || tick || !active) done_q <= 1'b0;
        else if (done)              done_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_OFF;
            pc_q   <= '0;
        end else if (tick) begin
            mode_q <= mode_req_q;
            if (resets_pc(mode_q, mode_req_q)) pc_q <= '0;
            else if (pcv_q)                    pc_q <= pcreq_q;
            else if (step)                     pc_q <= pc_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SLOTS; i++) mem_q[i] <= '0;
        end else if (mem_we && mode_q == MODE_LOAD) begin
            mem_q[mem_addr] <= mem_wdata;
        end
    end

    assign mem_rdata   = (mode_q == MODE_LOAD) ? mem_q[mem_addr] : '0;
    assign instr       = mem_q[pc_q];
    assign pc          = pc_q;
    assign is_load     = (mode_q == MODE_LOAD);
    assign flags.valid = active;
    assign flags.hold  = frozen;
    assign flags.zero  = (mode_q == MODE_OFF);

    // R2: the applied mode moves only on a slow tick
    a_r2_mode_on_tick: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(mode_q));
    // R3: an off channel sits at slot 0
    a_r3_off_pc_zero: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_OFF) |-> (pc_q == '0));
    // R4: entering load leaves the counter at 0
    a_r4_load_entry: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_LOAD && $past(mode_q) != MODE_LOAD) |-> (pc_q == '0));
    // R6: the counter changes only on a slow tick
    a_r6_pc_on_tick: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(pc_q));
    // R6, R7: a running channel moves by at most one slot per tick
    a_r6_one_step: assert property (@(posedge clk) disable iff (rst)
        (tick && mode_q == MODE_RUN && mode_req_q == MODE_RUN && !pcv_q)
        |=> (pc_q == $past(pc_q) || pc_q == $past(pc_q) + 1'b1));
    // R9: a frozen running channel keeps its slot
    a_r9_frozen_still: assert property (@(posedge clk) disable iff (rst)
        (frozen && mode_q == MODE_RUN && mode_req_q == MODE_RUN && !pcv_q)
        |=> $stable(pc_q));
    // R10: a held channel keeps its slot
    a_r10_hold_still: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_HOLD && mode_req_q == MODE_HOLD && !pcv_q)
        |=> $stable(pc_q));

endmodule

// File: rtl/led_seq_top.sv
module led_seq_top
    import led_seq_pkg::*;
#(
    parameter int NUM_CH   = 3,
    parameter int SLOTS    = 16,
    parameter int IW       = 16,
    parameter int TICK_DIV = 7813,
    parameter int PC_W     = $clog2(SLOTS),
    parameter int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   mode_wr,
    input  logic [2*NUM_CH-1:0]    mode_val,
    input  logic                   pc_wr,
    input  logic [CH_W-1:0]        pc_ch,
    input  logic [PC_W-1:0]        pc_val,
    input  logic                   mem_wr,
    input  logic [CH_W-1:0]        mem_ch,
    input  logic [PC_W-1:0]        mem_addr,
    input  logic [IW-1:0]          mem_wdata,
    output logic [IW-1:0]          mem_rdata,
    input  logic [NUM_CH-1:0]      exec_done,
    output logic [NUM_CH*IW-1:0]   instr,
    output logic [NUM_CH-1:0]      instr_valid,
    output logic [NUM_CH*PC_W-1:0] pc_out,
    output logic [NUM_CH-1:0]      pwm_hold,
    output logic [NUM_CH-1:0]      zero_cur
);
    logic              tick;
    logic [NUM_CH-1:0] is_load;
    logic              any_load;
    logic [IW-1:0]     ch_rdata [NUM_CH];

    assign any_load = |is_load;

    led_seq_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            chan_flags_t fl;

            led_seq_chan #(.SLOTS(SLOTS), .IW(IW), .PC_W(PC_W)) u_chan (
                .clk       (clk),
                .rst       (rst),
                .tick      (tick),
                .mode_wr   (mode_wr),
                .mode_new  (decode_mode(mode_val[2*c +: 2])),
                .pc_wr     (pc_wr && pc_ch == CH_W'(c)),
                .pc_new    (pc_val),
                .mem_we    (mem_wr && mem_ch == CH_W'(c)),
                .mem_addr  (mem_addr),
                .mem_wdata (mem_wdata),
                .mem_rdata (ch_rdata[c]),
                .done      (exec_done[c]),
                .frozen    (any_load && !is_load[c]),
                .is_load   (is_load[c]),
                .pc        (pc_out[PC_W*c +: PC_W]),
                .instr     (instr[IW*c +: IW]),
                .flags     (fl)
            );

            assign instr_valid[c] = fl.valid;
            assign pwm_hold[c]    = fl.hold;
            assign zero_cur[c]    = fl.zero;

            // R1, R9: a channel never runs while off or frozen
            a_r9_valid_excl: assert property (@(posedge clk) disable iff (rst)
                instr_valid[c] |-> (!pwm_hold[c] && !zero_cur[c]));
            // R9: a loading channel is never itself held
            a_r9_loader_free: assert property (@(posedge clk) disable iff (rst)
                is_load[c] |-> !pwm_hold[c]);
        end
    endgenerate

    always_comb begin
        mem_rdata = '0;
        for (int c = 0; c < NUM_CH; c++)
            if (mem_ch == CH_W'(c)) mem_rdata = ch_rdata[c];
    end

endmodule

// File: tb/tb_led_seq_top.sv
module tb_led_seq_top;
    localparam int NCH = 3;
    localparam int SL  = 16;
    localparam int IW  = 16;
    localparam int DIV = 4;
    localparam int PW  = 4;
    localparam int CW  = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            mode_wr = 1'b0;
    logic [2*NCH-1:0] mode_val = '0;
    logic            pc_wr = 1'b0;
    logic [CW-1:0]   pc_ch = '0;
    logic [PW-1:0]   pc_val = '0;
    logic            mem_wr = 1'b0;
    logic [CW-1:0]   mem_ch = '0;
    logic [PW-1:0]   mem_addr = '0;
    logic [IW-1:0]   mem_wdata = '0;
    logic [IW-1:0]   mem_rdata;
    logic [NCH-1:0]  exec_done = '0;
    logic [NCH*IW-1:0] instr;
    logic [NCH-1:0]  instr_valid;
    logic [NCH*PW-1:0] pc_out;
    logic [NCH-1:0]  pwm_hold;
    logic [NCH-1:0]  zero_cur;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    led_seq_top #(.NUM_CH(NCH), .SLOTS(SL), .IW(IW), .TICK_DIV(DIV)) dut (
        .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_val(mode_val),
        .pc_wr(pc_wr), .pc_ch(pc_ch), .pc_val(pc_val),
        .mem_wr(mem_wr), .mem_ch(mem_ch), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .exec_done(exec_done),
        .instr(instr), .instr_valid(instr_valid), .pc_out(pc_out),
        .pwm_hold(pwm_hold), .zero_cur(zero_cur)
    );

    function automatic logic [IW-1:0] prog(input int c, input int i);
        return {4'(c + 1), 4'h5, 4'(i), 4'(15 - i)};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (3 * DIV) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_modes(input logic [1:0] m2, input logic [1:0] m1, input logic [1:0] m0);
        @(negedge clk);
        mode_val = {m2, m1, m0};
        mode_wr  = 1'b1;
        @(negedge clk);
        mode_wr  = 1'b0;
        settle();
    endtask

    task automatic set_pc(input int c, input int v);
        @(negedge clk);
        pc_ch = CW'(c); pc_val = PW'(v); pc_wr = 1'b1;
        @(negedge clk);
        pc_wr = 1'b0;
        settle();
    endtask

    task automatic wr_mem(input int c, input int a, input logic [IW-1:0] d);
        @(negedge clk);
        mem_ch = CW'(c); mem_addr = PW'(a); mem_wdata = d; mem_wr = 1'b1;
        @(negedge clk);
        mem_wr = 1'b0;
    endtask

    task automatic rd_mem(input string tag, input int c, input int a, input logic [IW-1:0] exp);
        @(negedge clk);
        mem_ch = CW'(c); mem_addr = PW'(a);
        #1;
        chk(tag, 32'(mem_rdata), 32'(exp));
    endtask

    task automatic pulse(input int c);
        @(negedge clk);
        exec_done[c] = 1'b1;
        @(negedge clk);
        exec_done[c] = 1'b0;
        settle();
    endtask

    function automatic int pc_of(input int c);
        return int'(pc_out[PW*c +: PW]);
    endfunction

    task automatic t_reset();
        chk("R1 zero_cur", 32'(zero_cur), 32'h7);
        chk("R1 instr_valid", 32'(instr_valid), 32'h0);
        chk("R1 pwm_hold", 32'(pwm_hold), 32'h0);
        chk("R1 pc_out", 32'(pc_out), 32'h0);
    endtask

    task automatic t_gate();
        wr_mem(1, 0, 16'hDEAD);
        rd_mem("R5 read of off channel", 1, 0, 16'h0);
        set_modes(2'b01, 2'b01, 2'b01);
        rd_mem("R5 dropped write", 1, 0, 16'h0);
        chk("R9 all loading no hold", 32'(pwm_hold), 32'h0);
        chk("R4 load pc", 32'(pc_out), 32'h0);
    endtask

    task automatic t_load();
        for (int c = 0; c < NCH; c++)
            for (int i = 0; i < SL; i++) wr_mem(c, i, prog(c, i));
        rd_mem("R5 readback ch0 s15", 0, 15, prog(0, 15));
        rd_mem("R5 readback ch2 s7", 2, 7, prog(2, 7));
        chk("R9 loading not valid", 32'(instr_valid), 32'h0);
    endtask

    task automatic t_run();
        set_modes(2'b10, 2'b10, 2'b10);
        chk("R6 all valid", 32'(instr_valid), 32'h7);
        chk("R6 ch0 slot0", 32'(instr[IW-1:0]), 32'(prog(0, 0)));
        rd_mem("R5 read in run", 0, 3, 16'h0);
        for (int k = 0; k < 3; k++) pulse(0);
        chk("R6 ch0 pc after 3", 32'(pc_of(0)), 32'd3);
        chk("R6 ch0 slot3", 32'(instr[IW-1:0]), 32'(prog(0, 3)));
        chk("R6 ch1 untouched", 32'(pc_of(1)), 32'd0);
    endtask

    task automatic t_pcset_wrap();
        set_pc(1, 14);
        chk("R8 ch1 pc", 32'(pc_of(1)), 32'd14);
        chk("R8 ch1 instr", 32'(instr[IW +: IW]), 32'(prog(1, 14)));
        pulse(1);
        chk("R7 ch1 pc 15", 32'(pc_of(1)), 32'd15);
        pulse(1);
        chk("R7 ch1 wrap", 32'(pc_of(1)), 32'd0);
        chk("R7 ch1 instr slot0", 32'(instr[IW +: IW]), 32'(prog(1, 0)));
    endtask

    task automatic t_freeze();
        pulse(2);
        chk("R6 ch2 pc 1", 32'(pc_of(2)), 32'd1);
        set_modes(2'b01, 2'b10, 2'b10);
        chk("R4 ch2 load reset", 32'(pc_of(2)), 32'd0);
        chk("R9 hold others", 32'(pwm_hold), 32'h3);
        chk("R9 none valid", 32'(instr_valid), 32'h0);
        pulse(0);
        chk("R9 frozen ch0 pc", 32'(pc_of(0)), 32'd3);
        set_modes(2'b10, 2'b10, 2'b10);
        chk("R9 resume valid", 32'(instr_valid), 32'h7);
        chk("R9 resume no hold", 32'(pwm_hold), 32'h0);
        chk("R9 resume slot", 32'(pc_of(0)), 32'd3);
        pulse(0);
        chk("R9 step after resume", 32'(pc_of(0)), 32'd4);
    endtask

    task automatic t_hold();
        set_modes(2'b10, 2'b10, 2'b11);
        chk("R2 hold code not valid", 32'(instr_valid[0]), 32'd0);
        chk("R2 hold code current on", 32'(zero_cur[0]), 32'd0);
        pulse(0);
        chk("R10 hold ignores done", 32'(pc_of(0)), 32'd4);
        set_modes(2'b10, 2'b10, 2'b10);
        pulse(0);
        chk("R10 run after hold", 32'(pc_of(0)), 32'd5);
    endtask

    task automatic t_off();
        set_pc(1, 6);
        chk("R8 ch1 pc 6", 32'(pc_of(1)), 32'd6);
        set_modes(2'b10, 2'b00, 2'b10);
        chk("R3 off zero current", 32'(zero_cur), 32'h2);
        chk("R3 off pc", 32'(pc_of(1)), 32'd0);
        set_pc(1, 9);
        chk("R3 off ignores pc write", 32'(pc_of(1)), 32'd0);
        chk("R3 off not valid", 32'(instr_valid), 32'h5);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_gate();
        t_load();
        t_run();
        t_pcset_wrap();
        t_freeze();
        t_hold();
        t_off();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule